// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores received Ethernet frames in memory buffers described by a ring of 16-byte descriptors that hardware and software share. When enabled, it loads the ring start from `ring_base` and reads the current descriptor over a word-wide memory port. If the owner flag shows that software still holds the descriptor, the engine reports that no buffer is available and parks. It reads the descriptor again on a poll-demand pulse or an auto-poll tick. If hardware owns the descriptor, the engine reads the buffer size and the buffer address, then accepts frame bytes and writes each one into the buffer.

The frame arrives as a byte stream with start and end markers. Error, broadcast and multicast qualifiers travel with the end byte. When the frame ends, or the buffer fills first, the engine writes back the descriptor's first word. This word carries the status fields and hands ownership to software in the same write, so it is the last access made for that descriptor. A frame longer than one buffer continues in the next descriptor. A buffer address whose low two bits are not `10` is refused: the frame is drained without any memory writes and a bus error is reported.

Descriptor layout, at byte offsets from the descriptor start: +0 holds control and status, +4 holds the ring-end flag in bit 31 and the buffer size in bits 10:0, +8 holds the buffer byte address, and +12 is unused.

Top module: `rxring_engine`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, with `enable` low, `mem_req`, `rx_ready` and both `irq_pulse` bits are 0.
- R2: When `enable` rises, the engine reads the word at `ring_base`. If bit 31 of that word is 0 (software owns the descriptor), `irq_pulse[1]` pulses for one cycle and the engine makes no memory access until `poll_demand` or `autopoll_tick` is seen. It then reads the same address again.
- R3: When bit 31 of the first word is 1, the engine reads the words at descriptor +4 and +8, in that order, and then raises `rx_ready`. `rx_ready` is never high while a memory request is open.
- R4: Each accepted byte is written with exactly one byte enable. The write goes to the word address `(buffer + n) & ~3` at byte lane `(buffer + n) mod 4`, where n is the number of bytes already stored in this descriptor.
- R5: When the buffer address satisfies `addr mod 4 != 2`, the frame's bytes are accepted and discarded with no memory write. The status word then has bit 18 (bus error), bit 29 and bit 28 set and a length of 0.
- R6: The status write goes to descriptor +0 with all byte enables set, after the buffer data. In the status word, bit 31 is 0, bit 29 is set if this descriptor holds the frame's first byte, and bit 28 is set if it holds the last byte. Bits 22..19 carry `rx_err[3:0]`, where bit 22 is odd nibble, bit 21 is runt, bit 20 is too long and bit 19 is CRC. Bit 17 is broadcast, bit 16 is multicast, and bits 10:0 hold the number of bytes stored.
- R7: A byte that arrives when the buffer already holds the buffer-size count of bytes closes the descriptor with bit 29 as set, bit 28 clear, the length equal to the buffer size and no error flags. The byte is then stored in the next descriptor, which has bit 29 clear.
- R8: `irq_pulse[0]` pulses for one cycle after the status write of a descriptor that has bit 28 set and no error bit set (bits 22..18). The two interrupt bits are never high together.
- R9: After a status write, the next fetch goes to `ring_base` if the descriptor's +4 word had bit 31 set. Otherwise it goes to the descriptor address plus 16.
- R10: A memory request keeps `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable, sampled while idle or parked |
| ring_base | input | AW | Byte address of the first descriptor |
| poll_demand | input | 1 | Software request to re-read a parked descriptor |
| autopoll_tick | input | 1 | Periodic re-read request |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 4 | MAC error flags, valid with `rx_eof` |
| rx_bcast | input | 1 | Broadcast frame, valid with `rx_eof` |
| rx_mcast | input | 1 | Multicast frame, valid with `rx_eof` |
| rx_ready | output | 1 | Byte is taken on `rx_valid && rx_ready` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes; read data is valid |
| mem_rdata | input | 32 | Read data |
| irq_pulse | output | 2 | Bit 0: frame received; bit 1: no buffer available |

## Verification
Some properties are checked on every cycle: requests are held stable until acknowledged, a byte write has a single byte enable and never targets a refused buffer, every status write releases ownership, `rx_ready` and an open request never coincide, and the interrupt pulses last one cycle, never overlap, and follow a completed status write. Other behaviour can only be shown by the bench's scenarios. This covers the exact status word contents, the lane placement of bytes inside memory, the split of a long frame across two descriptors, the wrap to the ring start, the re-read after a poll event, and the absence of interrupts for frames with errors.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_W     = 11;
    localparam int MERR_W    = 4;

    // descriptor word +0 fields
    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 29;
    localparam int LAST_BIT  = 28;
    localparam int ERR_HI    = 22;
    localparam int BUS_BIT   = 18;
    localparam int BCAST_BIT = 17;
    localparam int MCAST_BIT = 16;

    // descriptor word +4 fields
    localparam int END_BIT   = 31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CTL,
        S_RD_SIZE,
        S_RD_BUF,
        S_PARK,
        S_OPEN,
        S_PUT,
        S_CLOSE
    } fsm_e;

endpackage

// File: rtl/rxring_status.sv
module rxring_status
    import rxring_pkg::*;
(
    input  logic              first,
    input  logic              last,
    input  logic [MERR_W-1:0] mac_err,
    input  logic              bus_err,
    input  logic              bcast,
    input  logic              mcast,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] word
);

    // the owner bit stays 0: this word hands the descriptor to software
    always_comb begin
        word                      = '0;
        word[FIRST_BIT]           = first;
        word[LAST_BIT]            = last;
        word[ERR_HI -: MERR_W]    = mac_err;
        word[BUS_BIT]             = bus_err;
        word[BCAST_BIT]           = bcast;
        word[MCAST_BIT]           = mcast;
        word[LEN_W-1:0]           = len;
    end

endmodule

// File: rtl/rxring_lane.sv
module rxring_lane
    import rxring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]       buf_base,
    input  logic [LEN_W-1:0]    offset,
    input  logic [7:0]          byte_in,
    output logic                addr_ok,
    output logic [AW-1:0]       word_addr,
    output logic [WORD_W/8-1:0] be,
    output logic [WORD_W-1:0]   wdata
);

    localparam int LANES = WORD_W / 8;
    localparam int LSB   = $clog2(LANES);

    logic [AW-1:0] byte_addr;

    assign byte_addr = buf_base + AW'(offset);
    assign word_addr = {byte_addr[AW-1:LSB], {LSB{1'b0}}};
    // only half-word aligned, not word aligned, buffers are usable
    assign addr_ok   = (buf_base[LSB-1:0] == LSB'(LANES / 2));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign be[l]          = (byte_addr[LSB-1:0] == LSB'(l));
        assign wdata[8*l +: 8] = byte_in;
    end

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [AW-1:0]     ring_base,
    input  logic              poll_demand,
    input  logic              autopoll_tick,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [MERR_W-1:0] rx_err,
    input  logic              rx_bcast,
    input  logic              rx_mcast,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [1:0]        irq_pulse
);

    localparam int SIZE_OFS = 4;
    localparam int BUF_OFS  = 8;

    typedef struct packed {
        fsm_e              st;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     buf_base;
        logic [LEN_W-1:0]  size;
        logic              wrap;
        logic [LEN_W-1:0]  cnt;
        logic              first;
        logic              last;
        logic              eof;
        logic [MERR_W-1:0] err;
        logic              bc;
        logic              mc;
        logic [7:0]        data;
        logic [1:0]        irq;
    } regs_t;

    regs_t q, d;

    logic              lane_ok;
    logic [AW-1:0]     lane_addr;
    logic [3:0]        lane_be;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] stat_word;

    rxring_lane #(.AW(AW)) lane_i (
        .buf_base  (q.buf_base),
        .offset    (q.cnt),
        .byte_in   (q.data),
        .addr_ok   (lane_ok),
        .word_addr (lane_addr),
        .be        (lane_be),
        .wdata     (lane_wdata)
    );

    rxring_status status_i (
        .first   (q.first),
        .last    (q.last),
        .mac_err (q.err),
        .bus_err (!lane_ok),
        .bcast   (q.bc),
        .mcast   (q.mc),
        .len     (lane_ok ? q.cnt : '0),
        .word    (stat_word)
    );

    always_comb begin
        d         = q;
        d.irq     = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_be    = '0;
        mem_wdata = '0;
        rx_ready  = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (enable) begin
                    d.ptr = ring_base;
                    d.st  = S_RD_CTL;
                end
            end
            S_RD_CTL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        d.st = S_RD_SIZE;
                    end else begin
                        d.irq[1] = 1'b1;
                        d.st     = S_PARK;
                    end
                end
            end
            S_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + AW'(SIZE_OFS);
                if (mem_ack) begin
                    d.wrap = mem_rdata[END_BIT];
                    d.size = mem_rdata[LEN_W-1:0];
                    d.st   = S_RD_BUF;
                end
            end
            S_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + AW'(BUF_OFS);
                if (mem_ack) begin
                    d.buf_base = mem_rdata[AW-1:0];
                    d.st       = S_OPEN;
                end
            end
            S_PARK: begin
                if (!enable) begin
                    d.st = S_IDLE;
                end else if (poll_demand || autopoll_tick) begin
                    d.st = S_RD_CTL;
                end
            end
            S_OPEN: begin
                rx_ready = !lane_ok || (q.cnt < q.size);
                if (rx_valid) begin
                    if (rx_ready) begin
                        if (rx_sof) d.first = 1'b1;
                        if (rx_eof) begin
                            d.err = rx_err;
                            d.bc  = rx_bcast;
                            d.mc  = rx_mcast;
                        end
                        if (!lane_ok) begin
                            if (rx_eof) begin
                                d.last = 1'b1;
                                d.st   = S_CLOSE;
                            end
                        end else begin
                            d.data = rx_data;
                            d.eof  = rx_eof;
                            d.st   = S_PUT;
                        end
                    end else begin
                        // buffer full, frame continues in the next descriptor
                        d.last = 1'b0;
                        d.st   = S_CLOSE;
                    end
                end
            end
            S_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane_addr;
                mem_be    = lane_be;
                mem_wdata = lane_wdata;
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.eof) begin
                        d.last = 1'b1;
                        d.st   = S_CLOSE;
                    end else begin
                        d.st = S_OPEN;
                    end
                end
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = '1;
                mem_wdata = stat_word;
                if (mem_ack) begin
                    d.irq[0] = q.last && (q.err == '0) && lane_ok;
                    d.ptr    = q.wrap ? ring_base : q.ptr + AW'(STRIDE);
                    d.cnt    = '0;
                    d.first  = 1'b0;
                    d.last   = 1'b0;
                    d.eof    = 1'b0;
                    d.err    = '0;
                    d.bc     = 1'b0;
                    d.mc     = 1'b0;
                    d.st     = S_RD_CTL;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_pulse = q.irq;

endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk
    import rxring_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [AW-1:0]     mem_addr,
    input logic [3:0]        mem_be,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              rx_ready,
    input logic [1:0]        irq_pulse,
    input logic              lane_ok
);

    p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    p_no_write_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> lane_ok);

    p_owner_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[OWN_BIT]);

    p_ready_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req);

    p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse[0] && irq_pulse[1]));

    p_nobuf_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse[1] |=> !irq_pulse[1]);

    p_done_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse[0] |-> $past(mem_req && mem_we && mem_ack && mem_be == 4'hF));

endmodule

bind rxring_engine rxring_engine_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .rx_ready  (rx_ready),
    .irq_pulse (irq_pulse),
    .lane_ok   (lane_ok)
);

// File: tb/rxring_engine_tb.sv
`timescale 1ns/1ps
module rxring_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        poll_demand = 1'b0;
    logic        autopoll_tick = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [3:0]  rx_err = 4'h0;
    logic        rx_bcast = 1'b0;
    logic        rx_mcast = 1'b0;
    logic        rx_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic [1:0]  irq_pulse;

    always #2 clk = ~clk;

    rxring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base),
        .poll_demand(poll_demand), .autopoll_tick(autopoll_tick),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_err(rx_err), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_pulse(irq_pulse)
    );

    logic [31:0] mem [0:255];
    logic [31:0] tr_addr [0:255];
    logic        tr_st [0:255];
    int n_chk = 0, n_bad = 0;
    int n_acc = 0, n_bytewr = 0, n_statwr = 0, hold_err = 0;
    int n_irq0 = 0, n_irq1 = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // memory responder: sees a request, re-checks it one cycle later, then acknowledges
    initial begin
        bit          seen = 1'b0;
        logic [31:0] s_addr = 32'h0;
        logic        s_we = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                seen    = 1'b0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!seen) begin
                    seen   = 1'b1;
                    s_addr = mem_addr;
                    s_we   = mem_we;
                end else begin
                    if (mem_addr !== s_addr || mem_we !== s_we) hold_err++;
                    if (mem_we) begin
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                        if (mem_be == 4'hF) n_statwr++; else n_bytewr++;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                    end
                    tr_addr[n_acc[7:0]] = mem_addr;
                    tr_st[n_acc[7:0]]   = mem_we && (mem_be == 4'hF);
                    n_acc++;
                    mem_ack = 1'b1;
                    seen    = 1'b0;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_pulse[0]) n_irq0++;
                if (irq_pulse[1]) n_irq1++;
            end
        end
    end

    task automatic send_frame(input int len, input logic [7:0] base, input logic [3:0] err,
                              input logic bc, input logic mc);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = base + 8'(i);
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_err   = (i == len - 1) ? err : 4'h0;
            rx_bcast = (i == len - 1) ? bc : 1'b0;
            rx_mcast = (i == len - 1) ? mc : 1'b0;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_err = 4'h0; rx_bcast = 1'b0; rx_mcast = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R1 ready in reset", {31'h0, rx_ready}, 32'h0);
        check("R1 req in reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 ready after reset", {31'h0, rx_ready}, 32'h0);
        check("R1 req after reset", {31'h0, mem_req}, 32'h0);
        check("R1 irq after reset", {30'h0, irq_pulse}, 32'h0);
    endtask

    task automatic t_nobuf_then_poll();
        enable = 1'b1;
        wait_cyc(12);
        check("R2 nobuf pulse count", n_irq1, 1);
        check("R2 one fetch", n_acc, 1);
        check("R2 fetch at base", tr_addr[0], 32'h100);
        mem[8'h40] = 32'h8000_0000;
        wait_cyc(10);
        check("R2 silent while parked", n_acc, 1);
        autopoll_tick = 1'b1;
        wait_cyc(1);
        autopoll_tick = 1'b0;
        wait_cyc(14);
        check("R3 ready after fetch", {31'h0, rx_ready}, 32'h1);
        check("R3 access count", n_acc, 4);
        check("R2 refetch same addr", tr_addr[1], 32'h100);
        check("R3 size word read", tr_addr[2], 32'h104);
        check("R3 buffer word read", tr_addr[3], 32'h108);
        check("R2 no extra nobuf", n_irq1, 1);
    endtask

    task automatic t_good_frame();
        send_frame(5, 8'hA1, 4'h0, 1'b1, 1'b0);
        wait_cyc(20);
        check("R4 lanes 2,3 of word 0x200", mem[8'h80], 32'hA2A1_0000);
        check("R4 lanes 0..2 of word 0x204", mem[8'h81], 32'h00A5_A4A3);
        check("R4 byte write count", n_bytewr, 5);
        check("R6 status word", mem[8'h40], 32'h3002_0005);
        check("R6 status is access after data", {31'h0, tr_st[9]}, 32'h1);
        check("R6 status address", tr_addr[9], 32'h100);
        check("R9 next descriptor +16", tr_addr[10], 32'h110);
        check("R8 done pulse", n_irq0, 1);
    endtask

    task automatic t_error_frame();
        send_frame(3, 8'h51, 4'b0001, 1'b0, 1'b1);
        wait_cyc(20);
        check("R6 status with crc and mcast", mem[8'h44], 32'h3009_0003);
        check("R8 no done pulse on error", n_irq0, 1);
    endtask

    task automatic t_span_and_wrap();
        int idx;
        mem[8'h40] = 32'h8000_0000;
        mem[8'h44] = 32'h8000_0000;
        mem[8'h46] = 32'h0000_0244;
        send_frame(6, 8'hB0, 4'h0, 1'b0, 1'b0);
        wait_cyc(25);
        check("R7 first part status", mem[8'h48], 32'h2000_0004);
        check("R7 first part data lo", mem[8'hA0], 32'hB1B0_0000);
        check("R7 first part data hi", mem[8'hA1], 32'h0000_B3B2);
        check("R7 second part status", mem[8'h40], 32'h1000_0002);
        check("R7 second part data", mem[8'h80], 32'hB5B4_0000);
        check("R8 one done for split frame", n_irq0, 2);
        idx = -1;
        for (int k = 0; k < n_acc - 1; k++)
            if (tr_st[k] && tr_addr[k] == 32'h120) idx = k;
        check("R9 wrap located", {31'h0, idx >= 0}, 32'h1);
        if (idx >= 0) check("R9 wrap to ring base", tr_addr[idx + 1], 32'h100);
    endtask

    task automatic t_bad_address();
        int wr_before;
        wr_before = n_bytewr;
        send_frame(3, 8'hC0, 4'h0, 1'b0, 1'b0);
        wait_cyc(25);
        check("R5 bus error status", mem[8'h44], 32'h3004_0000);
        check("R5 no byte writes", n_bytewr, wr_before);
        check("R5 buffer untouched", mem[8'h91], 32'h0000_0053);
        check("R8 no done on bus error", n_irq0, 2);
        check("R2 nobuf on released descriptor", n_irq1, 2);
        check("R10 request held until ack", hold_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[8'h41] = 32'd64;         mem[8'h42] = 32'h0000_0202;
        mem[8'h44] = 32'h8000_0000;  mem[8'h45] = 32'd64;  mem[8'h46] = 32'h0000_0242;
        mem[8'h48] = 32'h8000_0000;  mem[8'h49] = 32'h8000_0004; mem[8'h4A] = 32'h0000_0282;
        t_reset();
        t_nobuf_then_poll();
        t_good_frame();
        t_error_frame();
        t_span_and_wrap();
        t_bad_address();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog on all requirements: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule